// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-up to a usable state before the normal memory controller takes over. A one-cycle start pulse launches the sequence. The block first waits a settle interval of a parameterized number of clock cycles. It then plays a fixed script of SDRAM commands: one precharge, a series of auto-refresh commands and one mode-register load. Every command occupies a single cycle and is followed by a fixed number of idle cycles. The settle wait and the whole script are performed twice, back to back.

The mode-register byte is derived from three configuration inputs: a CAS field, a clock-speed select and a bus-width select. How the CAS field is read depends on the speed select. A nonzero override byte replaces the derived value. Auto-refresh stays disabled until the second pass has finished. At that point a refresh-enable flag and a done flag rise together, and they hand control to normal operation.

The settle wait is a parameter. The default of 40000 cycles is 200 µs at 200 MHz, and a bench can set a much shorter value.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and afterwards until a start pulse is sampled, `cmd_o` is NOP (0), `refresh_en_o` is 0, `done_o` is 0 and `mode_data_o` is 0.
- R2: Command codes are NOP=0, MRS=1, REFRESH=2, PRECHARGE=3. Each pass issues, in order: PRECHARGE, NOP, then REFRESH_PAIRS (default 8) REFRESH/NOP pairs, then MRS, NOP. With the default this is 20 script slots.
- R3: The first command of a pass appears on `cmd_o` exactly SETTLE_CYCLES cycles after the cycle in which the start pulse was sampled. The start pulse is sampled at clock edge E0, and the first command is visible after edge E0+SETTLE_CYCLES.
- R4: Each script slot drives its command for exactly one cycle. It is followed by GAP_CYCLES (default 5) cycles of NOP, so consecutive script slots are GAP_CYCLES+1 cycles apart.
- R5: After the final idle gap of the first pass, a second full settle wait and script run at once. The second pass's first command comes SETTLE_CYCLES + 6*20 cycles after the first pass's first command (default parameters).
- R6: Without an override, `mode_data_o` is 0x40 for CAS 2 on a 32-bit bus, 0x60 for CAS 3 on a 32-bit bus, 0x20 for CAS 2 on a 16-bit bus and 0x30 for CAS 3 on a 16-bit bus. `wide_bus_i`=1 selects 32-bit. The value is captured when start is accepted and is visible from the next cycle.
- R7: The CAS field is read according to `fast_clk_i`. With `fast_clk_i`=1 (100 MHz), field value 0 means CAS 2. With `fast_clk_i`=0 (50 MHz), field value 1 means CAS 2. Every other value means CAS 3.
- R8: A nonzero `mode_override_i` sampled with the accepted start is driven on `mode_data_o` unchanged, in place of the derived value.
- R9: `refresh_en_o` is 0 for the whole sequence. In the cycle after the last idle gap of the second pass, `refresh_en_o` and `done_o` both become 1, and `cmd_o` stays NOP from then on.
- R10: `done_o` stays 1 until reset or a new start pulse. A new start pulse clears `done_o` and `refresh_en_o` in the next cycle and restarts the full sequence.
- R11: A start pulse sampled while a sequence is running has no effect. The command timing and the completion cycle stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle or done |
| cas_field_i | input | 2 | CAS latency field, interpreted according to the speed select |
| fast_clk_i | input | 1 | 1 = 100 MHz operation, 0 = 50 MHz |
| wide_bus_i | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| mode_override_i | input | 8 | Nonzero value replaces the derived mode byte |
| cmd_o | output | 2 | SDRAM command code (NOP/MRS/REFRESH/PRECHARGE) |
| mode_data_o | output | 8 | Mode-register data byte |
| refresh_en_o | output | 1 | Auto-refresh enable, set after the last pass |
| done_o | output | 1 | Initialization complete |

## Verification
The bench predicts the absolute cycle of every non-NOP command across both passes. A design that miscounts the settle wait or the idle gap, or that skips or shortens the second pass, therefore shows up as a command arriving in the wrong cycle or as a missing command. All four CAS/speed/width combinations are run, with the CAS field chosen so that a design which ignores the speed-dependent reading would produce the wrong byte. A nonzero override is also run, to catch a design that still uses the derived value. A start pulse injected mid-sequence would shift every later command if the design restarted on it. The bench also checks the exact completion cycle, that done holds, and that done clears on a fresh start.

// File: rtl/sdram_init_pkg.sv
// Package: shared command codes and sequencer state encoding for the
// SDRAM initialization sequencer.
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_MRS = 2'd1,
        CMD_REF = 2'd2,
        CMD_PRE = 2'd3
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_CMD    = 3'd2,
        ST_GAP    = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sdram_mode_calc.sv
// Derives the mode-register byte from CAS field, speed select and bus
// width; a nonzero override replaces the derived value.
// Assumes: purely combinational, inputs are stable when sampled by the
// caller.
module sdram_mode_calc #(
    parameter int MODE_W = 8
) (
    input  logic [1:0]        cas_field_i,
    input  logic              fast_clk_i,
    input  logic              wide_bus_i,
    input  logic [MODE_W-1:0] override_i,
    output logic [MODE_W-1:0] mode_o
);

    localparam logic [MODE_W-1:0] BASE_CAS2 = MODE_W'(8'h40);
    localparam logic [MODE_W-1:0] BASE_CAS3 = MODE_W'(8'h60);

    logic              cas_is_two;
    logic [MODE_W-1:0] wide_val;
    logic [MODE_W-1:0] derived;

    // Decode the CAS field according to the clock-speed select.
    always_comb begin
        if (fast_clk_i) cas_is_two = (cas_field_i == 2'd0);
        else            cas_is_two = (cas_field_i == 2'd1);
    end

    // Pick the 32-bit value and halve it for a 16-bit bus.
    always_comb begin
        wide_val = cas_is_two ? BASE_CAS2 : BASE_CAS3;
        derived  = wide_bus_i ? wide_val : (wide_val >> 1);
    end

    // A nonzero override wins over the derived value.
    always_comb begin
        mode_o = (override_i != '0) ? override_i : derived;
    end

endmodule

// File: rtl/sdram_init_script.sv
// Maps a script slot index to the SDRAM command issued in that slot:
// precharge, refresh/nop pairs, then mode-register set, each slot
// followed by a nop slot.
// Assumes: idx_i < SCRIPT_LEN.
module sdram_init_script
    import sdram_init_pkg::*;
#(
    parameter int REFRESH_PAIRS = 8,
    parameter int SCRIPT_LEN    = 2 * (REFRESH_PAIRS + 2),
    parameter int IDX_W         = $clog2(SCRIPT_LEN)
) (
    input  logic [IDX_W-1:0] idx_i,
    output sdram_cmd_e       cmd_o
);

    localparam logic [IDX_W-1:0] MRS_SLOT = IDX_W'(SCRIPT_LEN - 2);

    // Odd slots are idle; slot 0 precharges; the second-to-last loads mode.
    always_comb begin
        if (idx_i[0])                cmd_o = CMD_NOP;
        else if (idx_i == '0)        cmd_o = CMD_PRE;
        else if (idx_i == MRS_SLOT)  cmd_o = CMD_MRS;
        else                         cmd_o = CMD_REF;
    end

endmodule

// File: rtl/sdram_wait_timer.sv
// Loadable down-counter used for both the settle wait and the gap
// between commands; reports when it has reached zero.
// Assumes: synchronous active-low reset; load takes priority.
module sdram_wait_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer. On an accepted start pulse it
// captures the mode byte, waits SETTLE_CYCLES, plays the command script
// with GAP_CYCLES idle cycles after every slot, repeats the wait and
// script PASSES times, then raises refresh enable and done.
// Assumes: SETTLE_CYCLES >= 1, GAP_CYCLES >= 1; start ignored while busy.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int SETTLE_CYCLES = 40000,
    parameter int GAP_CYCLES    = 5,
    parameter int REFRESH_PAIRS = 8,
    parameter int PASSES        = 2,
    parameter int MODE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cas_field_i,
    input  logic              fast_clk_i,
    input  logic              wide_bus_i,
    input  logic [MODE_W-1:0] mode_override_i,
    output logic [1:0]        cmd_o,
    output logic [MODE_W-1:0] mode_data_o,
    output logic              refresh_en_o,
    output logic              done_o
);

    localparam int SCRIPT_LEN = 2 * (REFRESH_PAIRS + 2);
    localparam int IDX_W      = $clog2(SCRIPT_LEN);
    localparam int MAX_WAIT   = (SETTLE_CYCLES > GAP_CYCLES) ? SETTLE_CYCLES : GAP_CYCLES;
    localparam int CW         = $clog2(MAX_WAIT + 1);
    localparam int PASS_W     = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam logic [CW-1:0]     SETTLE_LOAD = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0]     GAP_LOAD    = CW'(GAP_CYCLES - 1);
    localparam logic [IDX_W-1:0]  LAST_SLOT   = IDX_W'(SCRIPT_LEN - 1);
    localparam logic [PASS_W-1:0] LAST_PASS   = PASS_W'(PASSES - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PASS_W-1:0] pass_q;
    logic [MODE_W-1:0] mode_q;
    logic              timer_load;
    logic [CW-1:0]     timer_val;
    logic              timer_zero;
    logic              accept_start;
    logic [MODE_W-1:0] mode_next;
    sdram_cmd_e        slot_cmd;

    sdram_mode_calc #(
        .MODE_W(MODE_W)
    ) u_mode (
        .cas_field_i (cas_field_i),
        .fast_clk_i  (fast_clk_i),
        .wide_bus_i  (wide_bus_i),
        .override_i  (mode_override_i),
        .mode_o      (mode_next)
    );

    sdram_init_script #(
        .REFRESH_PAIRS (REFRESH_PAIRS),
        .SCRIPT_LEN    (SCRIPT_LEN),
        .IDX_W         (IDX_W)
    ) u_script (
        .idx_i (idx_q),
        .cmd_o (slot_cmd)
    );

    sdram_wait_timer #(
        .CW(CW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .zero_o     (timer_zero)
    );

    // Start is honoured only from idle or after completion.
    assign accept_start = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // Timer reload: settle on start or pass restart, gap after each slot.
    always_comb begin
        timer_load = 1'b0;
        timer_val  = GAP_LOAD;
        if (accept_start) begin
            timer_load = 1'b1;
            timer_val  = SETTLE_LOAD;
        end else if (state_q == ST_CMD) begin
            timer_load = 1'b1;
            timer_val  = GAP_LOAD;
        end else if (state_q == ST_GAP && timer_zero && idx_q == LAST_SLOT
                     && pass_q != LAST_PASS) begin
            timer_load = 1'b1;
            timer_val  = SETTLE_LOAD;
        end
    end

    // Main sequencing: settle, command slot, gap, next slot or next pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pass_q  <= '0;
        end else if (accept_start) begin
            state_q <= ST_SETTLE;
            idx_q   <= '0;
            pass_q  <= '0;
        end else begin
            case (state_q)
                ST_SETTLE: if (timer_zero) state_q <= ST_CMD;
                ST_CMD:    state_q <= ST_GAP;
                ST_GAP: begin
                    if (timer_zero) begin
                        if (idx_q != LAST_SLOT) begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_CMD;
                        end else if (pass_q != LAST_PASS) begin
                            idx_q   <= '0;
                            pass_q  <= pass_q + 1'b1;
                            state_q <= ST_SETTLE;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Capture the mode byte when a sequence is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)            mode_q <= '0;
        else if (accept_start) mode_q <= mode_next;
    end

    // Drive outputs from the registered state.
    always_comb begin
        cmd_o        = (state_q == ST_CMD) ? slot_cmd : CMD_NOP;
        mode_data_o  = mode_q;
        refresh_en_o = (state_q == ST_DONE);
        done_o       = (state_q == ST_DONE);
    end

endmodule

// File: rtl/sdram_init_seq_chk.sv
// Checker for the SDRAM initialization sequencer, observing its ports
// only; bound to every instance of the top module.
module sdram_init_seq_chk #(
    parameter int MODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        cmd_o,
    input logic [MODE_W-1:0] mode_data_o,
    input logic              refresh_en_o,
    input logic              done_o
);

    // R4
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'd0) |=> (cmd_o == 2'd0));

    // R9
    refresh_off_during_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'd0) |-> (!refresh_en_o && !done_o));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (refresh_en_o && cmd_o == 2'd0));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && !refresh_en_o));

    // R6
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'd0) |=> $stable(mode_data_o));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .MODE_W(MODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmd_o        (cmd_o),
    .mode_data_o  (mode_data_o),
    .refresh_en_o (refresh_en_o),
    .done_o       (done_o)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: run_seq pushes the expected command stream with
// absolute cycle stamps; a negedge monitor pops and compares.
module sdram_init_seq_bench;

    localparam int S     = 30;
    localparam int GAP   = 5;
    localparam int SLOTS = 20;
    localparam int PASS_LEN = S + SLOTS * (GAP + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] cas_field_i = '0;
    logic       fast_clk_i = 1'b0;
    logic       wide_bus_i = 1'b0;
    logic [7:0] mode_override_i = '0;
    logic [1:0] cmd_o;
    logic [7:0] mode_data_o;
    logic       refresh_en_o;
    logic       done_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct { int stamp; logic [1:0] cmd; } exp_t;
    exp_t sb_q[$];

    sdram_init_seq #(
        .SETTLE_CYCLES(S),
        .GAP_CYCLES(GAP)
    ) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cas_field_i(cas_field_i), .fast_clk_i(fast_clk_i),
        .wide_bus_i(wide_bus_i), .mode_override_i(mode_override_i),
        .cmd_o(cmd_o), .mode_data_o(mode_data_o),
        .refresh_en_o(refresh_en_o), .done_o(done_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: every non-NOP command must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && cmd_o != 2'd0) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected command", int'(cmd_o), 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(cmd_o == e.cmd, "R2 command code", int'(cmd_o), int'(e.cmd));
                chk(cyc == e.stamp, "R3/R4/R5 command cycle", cyc, e.stamp);
                chk(!refresh_en_o, "R9 refresh during sequence", int'(refresh_en_o), 0);
            end
        end
    end

    function automatic logic [7:0] exp_mode(input logic [1:0] f, input bit fast,
                                            input bit wide, input logic [7:0] ovr);
        bit two;
        logic [7:0] v;
        if (ovr != 0) return ovr;
        two = fast ? (f == 2'd0) : (f == 2'd1);
        v = two ? 8'h40 : 8'h60;
        return wide ? v : (v >> 1);
    endfunction

    task automatic run_seq(input logic [1:0] f, input bit fast, input bit wide,
                           input logic [7:0] ovr, input bit poke);
        int base;
        logic [7:0] m;
        m = exp_mode(f, fast, wide, ovr);
        @(negedge clk);
        cas_field_i = f; fast_clk_i = fast; wide_bus_i = wide; mode_override_i = ovr;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        base = cyc;
        for (int p = 0; p < 2; p++) begin
            for (int j = 0; j < SLOTS; j += 2) begin
                exp_t e;
                e.stamp = base + p * PASS_LEN + S + j * (GAP + 1);
                e.cmd = (j == 0) ? 2'd3 : ((j == SLOTS - 2) ? 2'd1 : 2'd2);
                sb_q.push_back(e);
            end
        end
        // R10: a new start clears done and refresh in the next cycle
        chk(!done_o && !refresh_en_o, "R10 done cleared by start",
            int'({done_o, refresh_en_o}), 0);
        // R6 R7 R8
        chk(mode_data_o == m, "R6/R7/R8 mode data", int'(mode_data_o), int'(m));
        if (poke) begin
            while (cyc < base + S + 10) @(negedge clk);
            start_i = 1'b1;   // R11: ignored mid-sequence
            @(negedge clk);
            start_i = 1'b0;
        end
        while (cyc < base + 2 * PASS_LEN - 1) @(negedge clk);
        chk(!done_o && !refresh_en_o, "R9 not done before final gap ends",
            int'({done_o, refresh_en_o}), 0);
        @(negedge clk);
        chk(done_o && refresh_en_o && cmd_o == 2'd0, "R9 done with refresh enabled",
            int'({done_o, refresh_en_o, cmd_o}), 'b1100);
        chk(sb_q.size() == 0, "R5 all commands of both passes seen", sb_q.size(), 0);
        repeat (8) @(negedge clk);
        chk(done_o && refresh_en_o, "R10 done held", int'({done_o, refresh_en_o}), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        chk(cmd_o == 0 && !refresh_en_o && !done_o && mode_data_o == 0,
            "R1 reset state", int'({cmd_o, refresh_en_o, done_o, mode_data_o}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cmd_o == 0 && !refresh_en_o && !done_o && mode_data_o == 0,
            "R1 idle before start", int'({cmd_o, refresh_en_o, done_o, mode_data_o}), 0);
        run_seq(2'd0, 1'b1, 1'b1, 8'h00, 1'b1); // R7 fast, CAS2, 32-bit: 0x40, R11 poke
        run_seq(2'd1, 1'b1, 1'b0, 8'h00, 1'b0); // R7 fast, field 1 -> CAS3, 16-bit: 0x30
        run_seq(2'd1, 1'b0, 1'b0, 8'h00, 1'b0); // R7 slow, field 1 -> CAS2, 16-bit: 0x20
        run_seq(2'd0, 1'b0, 1'b1, 8'h00, 1'b1); // R7 slow, field 0 -> CAS3, 32-bit: 0x60
        run_seq(2'd2, 1'b0, 1'b1, 8'h5A, 1'b0); // R8 override
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule